// File: doc/BRIEF.md
# Radix-2² Delay-Feedback FFT Stage Pair

This block is one stage pair of a streaming FFT pipeline built from single-path delay-feedback butterflies. It accepts one complex sample per clock when `in_valid` is high and returns one complex sample for each accepted input. Inside, two radix-2 butterfly units sit in cascade. Each unit owns a feedback shift register. The first unit pairs samples `D1 = N >> (2*PAIR+1)` apart. The second pairs samples `D2 = D1/2` apart and folds a multiply by -j into a swap of the real and imaginary parts plus a negation. One binary counter, `log2(N)` bits wide, supplies every multiplexer select.

Each unit spends half of its period filling its register and half combining. In the fill half, the incoming operand is written into the register and the oldest stored word leaves toward the output. In the combine half, the sum of the oldest stored word and the incoming operand goes to the output, and their difference is written back. Seen from the ports, the pair splits the stream into back-to-back sub-blocks of `L = 4*Q` samples, with `Q = D2`. For each sub-block it emits four 4-point DFTs on the samples `u[n], u[n+Q], u[n+2Q], u[n+3Q]`, in the frequency order 0, 2, 1, 3. The non-trivial twiddle multiply that follows the pair uses `out_pos` as its read address. A pipeline of `log4(N)` such pairs, with twiddle multipliers between them, forms a full FFT.

Stalls are exact: when `in_valid` is low the block holds all of its state. Each butterfly widens its result by one bit, so the outputs are two bits wider than the inputs and never wrap.

Top module: `r22_sdf_pair`

## Requirements
- R1: On a clock edge with `rst` high, the block clears its counter and priming state and drives `out_valid` low. After reset, `out_valid` first rises on the edge that accepts valid input number `LAT+1`, where `LAT = D1 + D2` (6 for N=32, PAIR=1). After that, `out_valid` is high on exactly the edges that accept an input.
- R2: `out_pos` equals `(s*L + i) mod N` for output `i` (0-based) of sub-block `s` counted since reset. It is therefore 0 on the first valid output and rises by one per valid output, wrapping at N.
- R3: Within each sub-block, outputs 0..Q-1 are `Y0[n] = u[n]+u[n+Q]+u[n+2Q]+u[n+3Q]`. Outputs Q..2Q-1 are `Y2[n] = u[n]-u[n+Q]+u[n+2Q]-u[n+3Q]`.
- R4: Outputs 2Q..3Q-1 are `Y1[n] = u[n] - j*u[n+Q] - u[n+2Q] + j*u[n+3Q]`. This needs the -j rotation on the second unit's incoming operand.
- R5: Outputs 3Q..4Q-1 are `Y3[n] = u[n] + j*u[n+Q] - u[n+2Q] - j*u[n+3Q]`.
- R6: A clock edge with `in_valid` low changes no state. On that edge `out_valid` goes low and `out_re`, `out_im` and `out_pos` hold. The results of the stream are the same as those of the same samples sent without gaps.
- R7: `out_re` and `out_im` are signed, W+2 bits wide, and exact for any W-bit signed inputs, including all inputs equal to -2^(W-1) (Y0 = -2^(W+1)).
- R8: Sub-blocks start at the first valid input after reset and follow each other with no gap. Every accepted sub-block's L results come out once, in order, after LAT further inputs.
- R9: A reset asserted mid-stream discards any partial sub-block. Stream alignment and the R1 latency restart from the first valid input after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present; also the advance enable of the whole pair |
| in_re | input | W | Input real part, signed |
| in_im | input | W | Input imaginary part, signed |
| out_valid | output | 1 | Output sample present |
| out_re | output | W+2 | Output real part, signed |
| out_im | output | W+2 | Output imaginary part, signed |
| out_pos | output | log2(N) | Position of the output sample within the N-sample frame (twiddle address) |

## Verification
The hardest case to reach from the ports is the -j rotation meeting a stall. Only one quarter of each sub-block passes through the rotation, and it is easy to get wrong. If the enable slips against the counter bits that select it, a stall at the wrong moment moves the rotation onto the wrong samples. The stimulus therefore inserts idle gaps at several fixed positions inside random sub-blocks, including the positions that feed the rotated quarter, and compares every result against a direct 4-point DFT sum. Impulses placed at offset Q and full-scale negative blocks drive the rotated path and the widest sums. A reset issued with valid input still arriving, halfway through a sub-block, shows that alignment restarts.

// File: rtl/r22_pkg.sv
package r22_pkg;

    // Butterfly mode: store incoming operand, or combine with the oldest stored word
    typedef enum logic {
        PH_FILL = 1'b0,
        PH_BFLY = 1'b1
    } bf_phase_e;

    // Per-unit control derived from the shared counter
    typedef struct packed {
        bf_phase_e phase;
        logic      rot;     // apply -j to the incoming operand
    } bf_ctrl_t;

    // Feedback register length of unit 0 or 1 inside stage pair `pair`
    function automatic int unit_depth(int n, int pair, int unit);
        return n >> (2 * pair + unit + 1);
    endfunction

endpackage

// File: rtl/r22_delay.sv
module r22_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (DEPTH == 1) begin : g_single
            logic [WIDTH-1:0] q;
            always_ff @(posedge clk) begin
                if (en) q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [WIDTH-1:0] taps [DEPTH];
            always_ff @(posedge clk) begin
                if (en) begin
                    taps[0] <= din;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end
            assign dout = taps[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/r22_bfly.sv
module r22_bfly
    import r22_pkg::*;
#(
    parameter int WI    = 16,
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 en,
    input  bf_ctrl_t             ctrl,
    input  logic signed [WI-1:0] in_re,
    input  logic signed [WI-1:0] in_im,
    output logic signed [WI:0]   out_re,
    output logic signed [WI:0]   out_im
);

    localparam int WO = WI + 1;

    typedef struct packed {
        logic signed [WO-1:0] re;
        logic signed [WO-1:0] im;
    } cplx_t;

    cplx_t             x_ext, x_op, head, wr, res;
    logic [2*WO-1:0]   head_bits;

    // Widen first so that the rotation and the sum cannot wrap
    always_comb begin
        x_ext.re = {in_re[WI-1], in_re};
        x_ext.im = {in_im[WI-1], in_im};
        if (ctrl.rot) begin
            // -j * (a + jb) = b - ja
            x_op.re = x_ext.im;
            x_op.im = -x_ext.re;
        end else begin
            x_op = x_ext;
        end
    end

    assign head = cplx_t'(head_bits);

    always_comb begin
        if (ctrl.phase == PH_BFLY) begin
            res.re = head.re + x_op.re;
            res.im = head.im + x_op.im;
            wr.re  = head.re - x_op.re;
            wr.im  = head.im - x_op.im;
        end else begin
            res = head;
            wr  = x_op;
        end
    end

    r22_delay #(
        .WIDTH (2 * WO),
        .DEPTH (DEPTH)
    ) u_fb (
        .clk  (clk),
        .en   (en),
        .din  (wr),
        .dout (head_bits)
    );

    assign out_re = res.re;
    assign out_im = res.im;

endmodule

// File: rtl/r22_sdf_pair.sv
module r22_sdf_pair
    import r22_pkg::*;
#(
    parameter int N    = 256,
    parameter int PAIR = 0,
    parameter int W    = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [W-1:0]    in_re,
    input  logic signed [W-1:0]    in_im,
    output logic                   out_valid,
    output logic signed [W+1:0]    out_re,
    output logic signed [W+1:0]    out_im,
    output logic [$clog2(N)-1:0]   out_pos
);

    localparam int AW  = $clog2(N);
    localparam int D1  = unit_depth(N, PAIR, 0);
    localparam int D2  = unit_depth(N, PAIR, 1);
    localparam int B1  = $clog2(D1);
    localparam int B2  = $clog2(D2);
    localparam int LAT = D1 + D2;
    localparam int SW  = $clog2(LAT + 1);

    logic [AW-1:0]       cnt;
    logic [SW-1:0]       seen;
    logic                primed;
    bf_ctrl_t            ctrl1, ctrl2;
    logic signed [W:0]   mid_re, mid_im;
    logic signed [W+1:0] fin_re, fin_im;

    assign primed = (seen == SW'(LAT));

    // Unit 0 sees the raw counter. Unit 1 sees the stream D1 samples later,
    // so its count is cnt - D1: bit B1 inverted, lower bits unchanged.
    always_comb begin
        ctrl1.phase = bf_phase_e'(cnt[B1]);
        ctrl1.rot   = 1'b0;
        ctrl2.phase = bf_phase_e'(cnt[B2]);
        ctrl2.rot   = ~cnt[B1] & cnt[B2];
    end

    r22_bfly #(
        .WI    (W),
        .DEPTH (D1)
    ) u_bf1 (
        .clk    (clk),
        .en     (in_valid),
        .ctrl   (ctrl1),
        .in_re  (in_re),
        .in_im  (in_im),
        .out_re (mid_re),
        .out_im (mid_im)
    );

    r22_bfly #(
        .WI    (W + 1),
        .DEPTH (D2)
    ) u_bf2 (
        .clk    (clk),
        .en     (in_valid),
        .ctrl   (ctrl2),
        .in_re  (mid_re),
        .in_im  (mid_im),
        .out_re (fin_re),
        .out_im (fin_im)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            seen      <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid & primed;
            if (in_valid) begin
                cnt <= cnt + 1'b1;
                if (!primed) seen <= seen + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_re  <= fin_re;
            out_im  <= fin_im;
            out_pos <= cnt - AW'(LAT);
        end
    end

endmodule

// File: rtl/r22_sdf_pair_chk.sv
module r22_sdf_pair_chk
    import r22_pkg::*;
#(
    parameter int N    = 256,
    parameter int PAIR = 0,
    parameter int W    = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [W+1:0]  out_re,
    input logic signed [W+1:0]  out_im,
    input logic [$clog2(N)-1:0] out_pos,
    input bf_ctrl_t             ctrl2
);

    localparam int AW  = $clog2(N);
    localparam int LAT = unit_depth(N, PAIR, 0) + unit_depth(N, PAIR, 1);
    localparam int CW  = $clog2(LAT + 2);

    // Valid inputs accepted since reset, saturating once the pipe is full
    logic [CW-1:0] acc;
    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else if (in_valid && acc != CW'(LAT + 1)) acc <= acc + 1'b1;
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> acc == CW'(LAT + 1));

    p_valid_src_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_pos_step_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_pos - $past(out_pos)) == AW'(1));

    p_rot_compute_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl2.rot |-> ctrl2.phase == PH_BFLY);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im) && $stable(out_pos)));

endmodule

bind r22_sdf_pair r22_sdf_pair_chk #(
    .N    (N),
    .PAIR (PAIR),
    .W    (W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_pos   (out_pos),
    .ctrl2     (ctrl2)
);

// File: tb/r22_sdf_pair_tb.sv
module r22_sdf_pair_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 32;
    localparam int PAIR = 1;
    localparam int W    = 8;
    localparam int Q    = N >> (2 * PAIR + 2);
    localparam int L    = 4 * Q;
    localparam int LAT  = 3 * Q;
    localparam int AW   = $clog2(N);
    localparam int WO   = W + 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [W-1:0]  in_re = '0;
    logic signed [W-1:0]  in_im = '0;
    logic                 out_valid;
    logic signed [WO-1:0] out_re, out_im;
    logic [AW-1:0]        out_pos;

    r22_sdf_pair #(.N(N), .PAIR(PAIR), .W(W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_pos(out_pos)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int    re;
        int    im;
        int    pos;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    fails = 0;
    int    blk = 0;
    int    acc = 0;
    bit    first_seen = 1'b0;
    bit    have_prev = 1'b0;
    string lat_tag = "R1";
    int    prev_re, prev_im, prev_pos;
    logic [15:0] lf = 16'hACE1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic int rnd8();
        for (int k = 0; k < 8; k++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return int'($signed(lf[7:0]));
    endfunction

    // Reference: four 4-point DFTs per sub-block, frequency order 0,2,1,3
    task automatic send_block(input int ure[L], input int uim[L], input int gaps,
                              input string tag_over);
        int qord[4];
        int idx;
        exp_t e;
        qord = '{0, 2, 1, 3};
        idx = 0;
        for (int qi = 0; qi < 4; qi++) begin
            for (int n = 0; n < Q; n++) begin
                int yre;
                int yim;
                yre = 0;
                yim = 0;
                for (int m = 0; m < 4; m++) begin
                    int a;
                    int b;
                    a = ure[n + m * Q];
                    b = uim[n + m * Q];
                    case ((m * qord[qi]) % 4)
                        0: begin yre += a; yim += b; end
                        1: begin yre += b; yim -= a; end
                        2: begin yre -= a; yim -= b; end
                        default: begin yre -= b; yim += a; end
                    endcase
                end
                e.re  = yre;
                e.im  = yim;
                e.pos = (blk * L + idx) % N;
                if (tag_over != "") e.tag = tag_over;
                else if (qord[qi] == 1) e.tag = "R4";
                else if (qord[qi] == 3) e.tag = "R5";
                else e.tag = "R3";
                exp_q.push_back(e);
                idx++;
            end
        end
        blk++;
        for (int i = 0; i < L; i++) begin
            if (gaps[i]) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(negedge clk);
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_re = ure[i][W-1:0];
            in_im = uim[i][W-1:0];
        end
    endtask

    task automatic flush();
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re = '0;
            in_im = '0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        check(exp_q.size() == 0, "R8", "results still pending", exp_q.size(), 0);
    endtask

    // Monitor: a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD / 4);
        if (rst) begin
            acc = 0;
            have_prev = 1'b0;
        end else begin
            if (in_valid) acc++;
            if (!in_valid && have_prev) begin
                check(out_valid == 1'b0, "R6", "out_valid on idle edge", int'(out_valid), 0);
                check(int'(out_re) == prev_re && int'(out_im) == prev_im && int'(out_pos) == prev_pos,
                      "R6", "output changed on idle edge", int'(out_re), prev_re);
            end
            if (out_valid) begin
                if (!first_seen) begin
                    first_seen = 1'b1;
                    check(acc == LAT + 1, lat_tag, "inputs before first valid output", acc, LAT + 1);
                end
                if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(out_re) == e.re, e.tag, "out_re", int'(out_re), e.re);
                    check(int'(out_im) == e.im, e.tag, "out_im", int'(out_im), e.im);
                    check(int'(out_pos) == e.pos, "R2", "out_pos", int'(out_pos), e.pos);
                end
            end
            have_prev = 1'b1;
            prev_re  = int'(out_re);
            prev_im  = int'(out_im);
            prev_pos = int'(out_pos);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", checks, 0);
        finish_up();
    end

    initial begin
        int ure[L];
        int uim[L];

        // R1: reset state
        repeat (3) @(posedge clk);
        #(CLK_PERIOD / 4);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #(CLK_PERIOD / 4);
        check(out_valid == 1'b0, "R1", "out_valid idle after reset", int'(out_valid), 0);

        // impulse at offset 0
        for (int i = 0; i < L; i++) begin ure[i] = 0; uim[i] = 0; end
        ure[0] = 100;
        send_block(ure, uim, 0, "");
        // impulse at offset Q drives the rotated path
        for (int i = 0; i < L; i++) begin ure[i] = 0; uim[i] = 0; end
        ure[Q] = 50; uim[Q] = -30;
        send_block(ure, uim, 0, "");
        // impulse at offset 3Q
        for (int i = 0; i < L; i++) begin ure[i] = 0; uim[i] = 0; end
        ure[3*Q+1] = -20; uim[3*Q+1] = 45;
        send_block(ure, uim, 0, "");
        // constant
        for (int i = 0; i < L; i++) begin ure[i] = 7; uim[i] = -3; end
        send_block(ure, uim, 0, "");
        // ramp
        for (int i = 0; i < L; i++) begin ure[i] = i * 10 - 40; uim[i] = 3 * i - 12; end
        send_block(ure, uim, 0, "");
        // random with idle gaps at several positions (R6)
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < L; i++) begin ure[i] = rnd8(); uim[i] = rnd8(); end
            send_block(ure, uim, (r == 0) ? 8'b0010_0101 : (r == 1) ? 8'b1100_1000 : 8'b0001_0110, "R6");
        end
        // full-scale negative (R7)
        for (int i = 0; i < L; i++) begin ure[i] = -128; uim[i] = -128; end
        send_block(ure, uim, 0, "R7");
        // alternating extremes (R7)
        for (int i = 0; i < L; i++) begin
            ure[i] = (i % 2 == 0) ? 127 : -128;
            uim[i] = ((i / Q) % 2 == 0) ? -128 : 127;
        end
        send_block(ure, uim, 0, "R7");
        // random without gaps, crosses the out_pos wrap
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < L; i++) begin ure[i] = rnd8(); uim[i] = rnd8(); end
            send_block(ure, uim, 0, "");
        end
        flush();

        // R9: reset mid sub-block with valid input still arriving
        for (int i = 0; i < L / 2; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re = 8'sd33;
            in_im = -8'sd17;
        end
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R9", "out_valid during mid-stream reset", int'(out_valid), 0);
        exp_q.delete();
        blk = 0;
        first_seen = 1'b0;
        lat_tag = "R9";
        rst = 1'b0;
        in_valid = 1'b0;
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < L; i++) begin ure[i] = rnd8(); uim[i] = rnd8(); end
            send_block(ure, uim, (r == 1) ? 8'b0100_0010 : 0, "R9");
        end
        flush();

        finish_up();
    end

endmodule